// File: doc/BRIEF.md
# SD Data FIFO Window Controller

This block runs the data stage of an SD card host. Software, or a DMA engine, moves 32-bit words through one register window. The card side exchanges single bytes with a data-line engine. A small word FIFO sits between the two sides. A control word sets the transfer direction, the block-size exponent, the FIFO level flags, DMA request generation and a FIFO flush. A 24-bit byte count sets how many bytes the card side moves before the transfer reports completion. A timeout count, reloaded on every byte moved, catches a card that stops moving data.

On a write transfer, words pushed into the window are sent to the card one byte at a time, least significant byte first. On a read transfer, bytes from the card are packed into words and become readable through the window. A short final word is zero-filled. The refill flag tells the feeder when the FIFO can take a burst. The drain flag tells it when words are waiting. A depth output tells software how many words make up one burst.

Top module: `sd_data_window`

## Requirements
- R1: The control word fields are: bits 3:0 the block-size exponent, bit 4 the write direction, bit 5 the DMA enable, bit 6 the data enable, bit 7 the half-level threshold and bit 8 the flush. `blockBytes` equals 1 shifted left by the exponent.
- R2: A control write with bit 6 set arms a transfer of the currently held 24-bit length. It clears the done and timeout flags. A control write with bit 6 clear disarms the transfer.
- R3: On a write transfer, each FIFO word is sent to the card least significant byte first. A byte moves on a cycle where `cardTxValid` and `cardTxReady` are both high. No byte is offered after the programmed length has been sent.
- R4: On a read transfer, a card byte is taken on a cycle where `cardRxValid` and `cardRxReady` are both high. Bytes fill a word from bit 0 upward. The word enters the FIFO after four bytes, or after the last byte of the length with the unfilled bytes set to zero. `winRdData` shows the oldest word, or zero when the FIFO is empty.
- R5: A window write is stored only on a write transfer with room in the FIFO; otherwise it is dropped. A window read removes a word only on a read transfer. `cardRxReady` stays low while the FIFO is full.
- R6: `underrunFlag` is high on an armed write transfer with bytes still to send and free space of at least the level. The level is the full depth, or half the depth when bit 7 is set.
- R7: `overrunFlag` is high on a read transfer when the FIFO holds at least the level of words, or holds any word after the whole length has been received.
- R8: `dataEnd` rises one cycle after the last byte moves, or one cycle after arming with a zero length. It stays high until the next control write.
- R9: A transfer that sees the programmed timeout count of card ticks with no byte moved raises `dataTimeout`. A count below one counts as one. After a timeout, no further byte moves until the next control write.
- R10: A control write with bit 8 set empties the FIFO and discards any partly sent or partly packed word.
- R11: `dmaReq` is high only when both DMA enable and data enable are set and the underrun or overrun flag is high.
- R12: `fifoDepthWords` reports the FIFO depth in 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 9 | Control word |
| lenWrEn | input | 1 | Length write strobe |
| lenWrData | input | 24 | Transfer length in bytes |
| timerWrEn | input | 1 | Timeout count write strobe |
| timerWrData | input | 16 | Timeout count in card ticks |
| winWrEn | input | 1 | Window write strobe |
| winWrData | input | 32 | Window write word |
| winRdEn | input | 1 | Window read strobe (pops) |
| winRdData | output | 32 | Oldest FIFO word or zero |
| cardTxValid | output | 1 | Byte offered to the card |
| cardTxByte | output | 8 | Byte to the card |
| cardTxReady | input | 1 | Card engine takes the byte |
| cardRxValid | input | 1 | Card engine offers a byte |
| cardRxByte | input | 8 | Byte from the card |
| cardRxReady | output | 1 | Block takes the byte |
| cardTick | input | 1 | One card clock period elapsed |
| underrunFlag | output | 1 | FIFO wants a refill |
| overrunFlag | output | 1 | FIFO wants a drain |
| dataEnd | output | 1 | Programmed length moved |
| dataTimeout | output | 1 | Data timeout reached |
| dmaReq | output | 1 | DMA service request |
| blockBytes | output | 16 | Decoded block size in bytes |
| fifoDepthWords | output | 8 | FIFO depth in words |

## Verification
Every output is a function of registered state only. A stimulus applied before a rising edge therefore shows at the outputs right after that edge. The exceptions are `dataEnd`, which needs one more edge after the last byte, and `dataTimeout`, which appears at the edge of the tick that exhausts the count. The bench drives inputs and compares against its behavioural queue model on falling edges only. The model steps on the same rising edges as the design, so each result is read in the cycle in which it is due. The directed checks count falling edges from the edge of the control write: the zero-length done flag is required low one edge after arming and high one edge later.

// File: rtl/sd_data_window_pkg.sv
package sd_data_window_pkg;
  // Control word bit positions (software-visible, fixed).
  localparam int BIT_WRITE  = 4;
  localparam int BIT_DMA    = 5;
  localparam int BIT_ENABLE = 6;
  localparam int BIT_THRESH = 7;
  localparam int BIT_FLUSH  = 8;
  localparam int CTRL_W     = 9;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic flush;
    logic writeDir;
    logic txEnable;
    logic rxEnable;
    logic lastByte;
  } dpCtl_t;
endpackage

// File: rtl/sd_data_window_ctrl.sv
module sd_data_window_ctrl
  import sd_data_window_pkg::*;
#(
  parameter int FIFO_WORDS = 4,
  parameter int LEN_W      = 24,
  parameter int TIMER_W    = 16,
  parameter int CNT_W      = $clog2(FIFO_WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic               lenWrEn,
  input  logic [LEN_W-1:0]   lenWrData,
  input  logic               timerWrEn,
  input  logic [TIMER_W-1:0] timerWrData,
  input  logic               cardTick,
  input  logic               byteMoved,
  input  logic [CNT_W-1:0]   fifoCount,
  output dpCtl_t             dpCtl,
  output logic               underrunFlag,
  output logic               overrunFlag,
  output logic               dmaReq,
  output logic               dataEnd,
  output logic               dataTimeout,
  output logic [15:0]        blockBytes
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_WORDS);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(FIFO_WORDS / 2);

  logic [CTRL_W-1:0]  ctrlQ;
  logic [LEN_W-1:0]   lenQ, remaining;
  logic [TIMER_W-1:0] timerQ, tmr;
  logic               armed, endQ, toQ;
  logic               active, bytesLeft;
  logic [CNT_W-1:0]   level, room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ     <= '0;
      lenQ      <= '0;
      timerQ    <= '0;
      remaining <= '0;
      tmr       <= '0;
      armed     <= 1'b0;
      endQ      <= 1'b0;
      toQ       <= 1'b0;
    end else begin
      if (lenWrEn)   lenQ   <= lenWrData;
      if (timerWrEn) timerQ <= timerWrData;
      if (ctrlWrEn) begin
        ctrlQ <= ctrlWrData;
        armed <= ctrlWrData[BIT_ENABLE];
        endQ  <= 1'b0;
        toQ   <= 1'b0;
        if (ctrlWrData[BIT_ENABLE]) begin
          remaining <= lenQ;
          tmr       <= timerQ;
        end
      end else if (armed) begin
        if (!bytesLeft) begin
          endQ  <= 1'b1;
          armed <= 1'b0;
        end else if (!toQ) begin
          if (byteMoved) begin
            remaining <= remaining - 1'b1;
            tmr       <= timerQ;
          end else if (cardTick) begin
            if (tmr <= TIMER_W'(1)) toQ <= 1'b1;
            else                    tmr <= tmr - 1'b1;
          end
        end
      end
    end
  end

  assign bytesLeft = (remaining != '0);
  assign active    = armed && bytesLeft && !toQ;
  assign level     = ctrlQ[BIT_THRESH] ? HALF_LVL : FULL_LVL;
  assign room      = FULL_LVL - fifoCount;

  always_comb begin
    dpCtl.flush    = ctrlWrEn && ctrlWrData[BIT_FLUSH];
    dpCtl.writeDir = ctrlQ[BIT_WRITE];
    dpCtl.txEnable = active && ctrlQ[BIT_WRITE];
    dpCtl.rxEnable = active && !ctrlQ[BIT_WRITE];
    dpCtl.lastByte = (remaining == LEN_W'(1));
  end

  assign underrunFlag = armed && ctrlQ[BIT_WRITE] && bytesLeft && (room >= level);
  assign overrunFlag  = !ctrlQ[BIT_WRITE] && (fifoCount != '0) &&
                        ((fifoCount >= level) || !bytesLeft);
  assign dmaReq       = ctrlQ[BIT_DMA] && ctrlQ[BIT_ENABLE] && (underrunFlag || overrunFlag);
  assign dataEnd      = endQ;
  assign dataTimeout  = toQ;
  assign blockBytes   = 16'(1) << ctrlQ[3:0];

  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    endQ |-> !armed);
  assert_timeout_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (toQ && !ctrlWrEn) |=> $stable(remaining));
  assert_move_in_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byteMoved |-> (armed && bytesLeft && !toQ));
endmodule

// File: rtl/sd_data_window_dp.sv
module sd_data_window_dp
  import sd_data_window_pkg::*;
#(
  parameter int FIFO_WORDS = 4,
  parameter int CNT_W      = $clog2(FIFO_WORDS + 1),
  parameter int AW         = $clog2(FIFO_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtl_t           dpCtl,
  input  logic             winWrEn,
  input  logic [31:0]      winWrData,
  input  logic             winRdEn,
  output logic [31:0]      winRdData,
  output logic             cardTxValid,
  output logic [7:0]       cardTxByte,
  input  logic             cardTxReady,
  input  logic             cardRxValid,
  input  logic [7:0]       cardRxByte,
  output logic             cardRxReady,
  output logic             byteMoved,
  output logic [CNT_W-1:0] fifoCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_WORDS);

  logic [31:0]      mem [FIFO_WORDS];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [31:0]      txWord, rxWord, rxWordNext, pushData;
  logic [2:0]       txCnt;
  logic [1:0]       rxCnt;
  logic             notFull, notEmpty;
  logic             winPush, winPop, txLoad, txMove, rxAccept, rxPush, push, pop;

  assign notFull    = (count < FULL_CNT);
  assign notEmpty   = (count != '0);
  assign winPush    = dpCtl.writeDir && winWrEn && notFull;
  assign winPop     = !dpCtl.writeDir && winRdEn && notEmpty;
  assign txLoad     = dpCtl.txEnable && (txCnt == 3'd0) && notEmpty;
  assign cardTxValid = dpCtl.txEnable && (txCnt != 3'd0);
  assign cardTxByte = txWord[7:0];
  assign txMove     = cardTxValid && cardTxReady;
  assign cardRxReady = dpCtl.rxEnable && notFull;
  assign rxAccept   = cardRxReady && cardRxValid;
  assign rxWordNext = rxWord | ({24'd0, cardRxByte} << {rxCnt, 3'b000});
  assign rxPush     = rxAccept && ((rxCnt == 2'd3) || dpCtl.lastByte);
  assign push       = winPush || rxPush;
  assign pop        = winPop || txLoad;
  assign pushData   = winPush ? winWrData : rxWordNext;
  assign byteMoved  = txMove || rxAccept;
  assign fifoCount  = count;
  assign winRdData  = notEmpty ? mem[rdPtr] : 32'd0;

  always_ff @(posedge clk) begin
    if (push && !dpCtl.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      txWord <= '0;
      txCnt  <= '0;
      rxWord <= '0;
      rxCnt  <= '0;
    end else if (dpCtl.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      txCnt  <= '0;
      rxWord <= '0;
      rxCnt  <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (txLoad) begin
        txWord <= mem[rdPtr];
        txCnt  <= 3'd4;
      end else if (txMove) begin
        txWord <= txWord >> 8;
        txCnt  <= txCnt - 3'd1;
      end
      if (rxPush) begin
        rxWord <= '0;
        rxCnt  <= '0;
      end else if (rxAccept) begin
        rxWord <= rxWordNext;
        rxCnt  <= rxCnt + 2'd1;
      end
    end
  end

  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtl.flush |=> (count == '0 && !cardTxValid));
  assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cardTxValid, cardRxReady}));
endmodule

// File: rtl/sd_data_window.sv
module sd_data_window
  import sd_data_window_pkg::*;
#(
  parameter int FIFO_WORDS = 4,
  parameter int LEN_W      = 24,
  parameter int TIMER_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrlWrEn,
  input  logic [8:0]         ctrlWrData,
  input  logic               lenWrEn,
  input  logic [LEN_W-1:0]   lenWrData,
  input  logic               timerWrEn,
  input  logic [TIMER_W-1:0] timerWrData,
  input  logic               winWrEn,
  input  logic [31:0]        winWrData,
  input  logic               winRdEn,
  output logic [31:0]        winRdData,
  output logic               cardTxValid,
  output logic [7:0]         cardTxByte,
  input  logic               cardTxReady,
  input  logic               cardRxValid,
  input  logic [7:0]         cardRxByte,
  output logic               cardRxReady,
  input  logic               cardTick,
  output logic               underrunFlag,
  output logic               overrunFlag,
  output logic               dataEnd,
  output logic               dataTimeout,
  output logic               dmaReq,
  output logic [15:0]        blockBytes,
  output logic [7:0]         fifoDepthWords
);
  localparam int CNT_W = $clog2(FIFO_WORDS + 1);

  dpCtl_t           dpCtl;
  logic             byteMoved;
  logic [CNT_W-1:0] fifoCount;

  sd_data_window_ctrl #(
    .FIFO_WORDS(FIFO_WORDS), .LEN_W(LEN_W), .TIMER_W(TIMER_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .timerWrEn(timerWrEn), .timerWrData(timerWrData),
    .cardTick(cardTick), .byteMoved(byteMoved), .fifoCount(fifoCount),
    .dpCtl(dpCtl),
    .underrunFlag(underrunFlag), .overrunFlag(overrunFlag), .dmaReq(dmaReq),
    .dataEnd(dataEnd), .dataTimeout(dataTimeout), .blockBytes(blockBytes)
  );

  sd_data_window_dp #(
    .FIFO_WORDS(FIFO_WORDS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtl(dpCtl),
    .winWrEn(winWrEn), .winWrData(winWrData),
    .winRdEn(winRdEn), .winRdData(winRdData),
    .cardTxValid(cardTxValid), .cardTxByte(cardTxByte), .cardTxReady(cardTxReady),
    .cardRxValid(cardRxValid), .cardRxByte(cardRxByte), .cardRxReady(cardRxReady),
    .byteMoved(byteMoved), .fifoCount(fifoCount)
  );

  assign fifoDepthWords = 8'(FIFO_WORDS);
endmodule

// File: tb/sd_data_window_tb.sv
`timescale 1ns/1ps
module sd_data_window_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrlWrEn = 1'b0, lenWrEn = 1'b0, timerWrEn = 1'b0;
  logic [8:0]  ctrlWrData = '0;
  logic [23:0] lenWrData = '0;
  logic [15:0] timerWrData = '0;
  logic        winWrEn = 1'b0, winRdEn = 1'b0, cardTxReady = 1'b0;
  logic        cardRxValid = 1'b0, cardTick = 1'b0;
  logic [31:0] winWrData = '0;
  logic [7:0]  cardRxByte = '0;
  logic [31:0] winRdData;
  logic        cardTxValid, cardRxReady, underrunFlag, overrunFlag;
  logic        dataEnd, dataTimeout, dmaReq;
  logic [7:0]  cardTxByte, fifoDepthWords;
  logic [15:0] blockBytes;

  sd_data_window u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .timerWrEn(timerWrEn), .timerWrData(timerWrData),
    .winWrEn(winWrEn), .winWrData(winWrData),
    .winRdEn(winRdEn), .winRdData(winRdData),
    .cardTxValid(cardTxValid), .cardTxByte(cardTxByte), .cardTxReady(cardTxReady),
    .cardRxValid(cardRxValid), .cardRxByte(cardRxByte), .cardRxReady(cardRxReady),
    .cardTick(cardTick),
    .underrunFlag(underrunFlag), .overrunFlag(overrunFlag),
    .dataEnd(dataEnd), .dataTimeout(dataTimeout), .dmaReq(dmaReq),
    .blockBytes(blockBytes), .fifoDepthWords(fifoDepthWords)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int mode = 0;
  int txCount = 0, rxCount = 0, popCount = 0;
  logic [31:0] lastPop = '0, pushCtr = '0;
  logic [7:0]  byteCtr = 8'd1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [8:0]  mCtrl;
  logic [23:0] mLen, mRem;
  logic [15:0] mTimerReg, mTmr;
  logic        mArmed, mEnd, mTo;
  logic [31:0] mQ[$];
  logic [31:0] mTxWord, mRxWord, mNw;
  int          mTxCnt, mRxCnt, mSz;
  bit          mTxEn, mRxEn, mTxV, mRxR, mMvTx, mMvRx;

  function automatic int mLevel();
    return mCtrl[7] ? DEPTH / 2 : DEPTH;
  endfunction
  function automatic bit mUnder();
    return mArmed && mCtrl[4] && mRem != 0 && (DEPTH - mQ.size()) >= mLevel();
  endfunction
  function automatic bit mOver();
    return !mCtrl[4] && mQ.size() != 0 && (mQ.size() >= mLevel() || mRem == 0);
  endfunction
  function automatic bit mTxValid();
    return mArmed && mCtrl[4] && mRem != 0 && !mTo && mTxCnt != 0;
  endfunction
  function automatic bit mRxReady();
    return mArmed && !mCtrl[4] && mRem != 0 && !mTo && mQ.size() < DEPTH;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCtrl = '0; mLen = '0; mRem = '0; mTimerReg = '0; mTmr = '0;
      mArmed = 0; mEnd = 0; mTo = 0; mQ.delete();
      mTxWord = '0; mTxCnt = 0; mRxWord = '0; mRxCnt = 0;
    end else begin
      mSz   = mQ.size();
      mTxEn = mArmed && mCtrl[4] && mRem != 0 && !mTo;
      mRxEn = mArmed && !mCtrl[4] && mRem != 0 && !mTo;
      mTxV  = mTxEn && mTxCnt != 0;
      mRxR  = mRxEn && mSz < DEPTH;
      mMvTx = mTxV && cardTxReady;
      mMvRx = mRxR && cardRxValid;
      if (ctrlWrEn && ctrlWrData[8]) begin
        mQ.delete(); mTxCnt = 0; mRxWord = '0; mRxCnt = 0;
      end else begin
        if (!mCtrl[4] && winRdEn && mSz != 0) void'(mQ.pop_front());
        if (mTxEn && mTxCnt == 0 && mSz != 0) begin
          mTxWord = mQ.pop_front(); mTxCnt = 4;
        end else if (mMvTx) begin
          mTxWord = mTxWord >> 8; mTxCnt--;
        end
        if (mCtrl[4] && winWrEn && mSz < DEPTH) mQ.push_back(winWrData);
        if (mMvRx) begin
          mNw = mRxWord | ({24'd0, cardRxByte} << (8 * mRxCnt));
          if (mRxCnt == 3 || mRem == 24'd1) begin
            mQ.push_back(mNw); mRxWord = '0; mRxCnt = 0;
          end else begin
            mRxWord = mNw; mRxCnt++;
          end
        end
      end
      if (ctrlWrEn) begin
        mCtrl = ctrlWrData; mArmed = ctrlWrData[6]; mEnd = 0; mTo = 0;
        if (ctrlWrData[6]) begin mRem = mLen; mTmr = mTimerReg; end
      end else if (mArmed) begin
        if (mRem == 0) begin mEnd = 1; mArmed = 0; end
        else if (!mTo) begin
          if (mMvTx || mMvRx) begin mRem = mRem - 24'd1; mTmr = mTimerReg; end
          else if (cardTick) begin
            if (mTmr <= 16'd1) mTo = 1; else mTmr = mTmr - 16'd1;
          end
        end
      end
      if (lenWrEn) mLen = lenWrData;
      if (timerWrEn) mTimerReg = timerWrData;
    end
  end

  // ------------- per-cycle comparison and stimulus agents -------------
  always @(negedge clk) begin
    if (rst_n) begin
      check(winRdData == (mQ.size() != 0 ? mQ[0] : 32'd0), "R4 winRdData", winRdData, (mQ.size() != 0 ? mQ[0] : 32'd0));
      check(cardTxValid == mTxValid(), "R3 cardTxValid", 32'(cardTxValid), 32'(mTxValid()));
      if (cardTxValid && mTxValid())
        check(cardTxByte == mTxWord[7:0], "R3 cardTxByte", 32'(cardTxByte), 32'(mTxWord[7:0]));
      check(cardRxReady == mRxReady(), "R5 cardRxReady", 32'(cardRxReady), 32'(mRxReady()));
      check(underrunFlag == mUnder(), "R6 underrunFlag", 32'(underrunFlag), 32'(mUnder()));
      check(overrunFlag == mOver(), "R7 overrunFlag", 32'(overrunFlag), 32'(mOver()));
      check(dataEnd == mEnd, "R8 dataEnd", 32'(dataEnd), 32'(mEnd));
      check(dataTimeout == mTo, "R9 dataTimeout", 32'(dataTimeout), 32'(mTo));
      check(dmaReq == (mCtrl[5] && mCtrl[6] && (mUnder() || mOver())), "R11 dmaReq",
            32'(dmaReq), 32'(mCtrl[5] && mCtrl[6] && (mUnder() || mOver())));
      check(blockBytes == (16'd1 << mCtrl[3:0]), "R1 blockBytes", 32'(blockBytes), 32'(16'd1 << mCtrl[3:0]));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    winWrEn = 0; winRdEn = 0; cardTxReady = 0; cardRxValid = 0; cardTick = 0;
    case (mode)
      1: begin
        cardTxReady = lfsr[0] | lfsr[1];
        winWrEn = lfsr[2];
        cardTick = lfsr[6];
      end
      2: begin
        cardRxValid = lfsr[0] | lfsr[3];
        winRdEn = lfsr[4];
        cardTick = lfsr[6];
      end
      3: cardTick = 1;
      4: cardRxValid = 1;
      5: begin winWrEn = 1; winWrData = 32'hDEADBEEF; end
      6: winWrEn = 1;
      7: cardTxReady = 1;
      default: ;
    endcase
    if (winWrEn && mode != 5) begin pushCtr = pushCtr + 32'd1; winWrData = pushCtr; end
    cardRxByte = byteCtr;
    if (cardTxValid && cardTxReady) txCount++;
    if (cardRxValid && cardRxReady) begin rxCount++; byteCtr = byteCtr + 8'd1; end
    if (winRdEn && winRdData != 32'd0) begin popCount++; lastPop = winRdData; end
  end

  task automatic regWr(input int which, input logic [31:0] v);
    @(negedge clk);
    case (which)
      0: begin ctrlWrEn = 1; ctrlWrData = v[8:0]; end
      1: begin lenWrEn = 1; lenWrData = v[23:0]; end
      default: begin timerWrEn = 1; timerWrData = v[15:0]; end
    endcase
    @(negedge clk);
    ctrlWrEn = 0; lenWrEn = 0; timerWrEn = 0;
  endtask

  task automatic goIdle();
    mode = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitEnd(input int limit);
    for (int i = 0; i < limit && !dataEnd; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check(winRdData == 0 && !cardTxValid && !cardRxReady, "R4 reset idle", winRdData, 0);
    check(!underrunFlag && !overrunFlag && !dmaReq, "R6 reset flags", {underrunFlag, overrunFlag, dmaReq}, 0);
    check(!dataEnd && !dataTimeout, "R8 reset status", {dataEnd, dataTimeout}, 0);
    check(blockBytes == 16'd1, "R1 reset blockBytes", blockBytes, 1);
    check(fifoDepthWords == 8'(DEPTH), "R12 fifoDepthWords", fifoDepthWords, DEPTH);

    // R1: block size decode
    regWr(0, 32'h000); check(blockBytes == 16'd1, "R1 exp0", blockBytes, 1);
    regWr(0, 32'h009); check(blockBytes == 16'd512, "R1 exp9", blockBytes, 512);
    regWr(0, 32'h00F); check(blockBytes == 16'd32768, "R1 exp15", blockBytes, 32768);

    // R3/R6/R8/R11: write transfer of 10 bytes with DMA
    regWr(0, 32'h100); regWr(2, 32'd1000); regWr(1, 32'd10);
    regWr(0, 32'h072);
    check(underrunFlag && dmaReq, "R11 dmaReq on refill", {underrunFlag, dmaReq}, 3);
    txCount = 0; mode = 1;
    waitEnd(3000);
    check(dataEnd == 1, "R8 write done", dataEnd, 1);
    check(txCount == 10, "R3 write byte count", txCount, 10);
    goIdle();

    // R11: DMA disabled keeps request low
    regWr(0, 32'h100); regWr(1, 32'd4); regWr(0, 32'h050);
    check(underrunFlag == 1 && dmaReq == 0, "R11 dma off", {underrunFlag, dmaReq}, 2);

    // R5: full FIFO drops window writes (write direction)
    regWr(0, 32'h100); regWr(1, 32'd100); regWr(0, 32'h050);
    pushCtr = 0; mode = 6; repeat (8) @(negedge clk);
    goIdle();
    check(underrunFlag == 0, "R6 full no refill", underrunFlag, 0);
    txCount = 0; mode = 7; repeat (40) @(negedge clk);
    check(txCount == 20, "R5 dropped words", txCount, 20);
    goIdle();

    // R4/R7: read transfer of 11 bytes, half threshold
    regWr(0, 32'h100); regWr(1, 32'd11);
    byteCtr = 8'd1; rxCount = 0; popCount = 0;
    regWr(0, 32'h0E3);
    mode = 2;
    waitEnd(3000);
    check(dataEnd == 1, "R8 read done", dataEnd, 1);
    repeat (60) @(negedge clk);
    goIdle();
    check(rxCount == 11, "R4 read byte count", rxCount, 11);
    check(popCount == 3, "R4 read word count", popCount, 3);
    check(lastPop == 32'h000B0A09, "R4 partial word zero fill", lastPop, 32'h000B0A09);

    // R5: window writes ignored on a read transfer
    regWr(0, 32'h100); regWr(1, 32'd4); regWr(0, 32'h040);
    mode = 5; repeat (5) @(negedge clk); goIdle();
    check(winRdData == 0 && !overrunFlag, "R5 write ignored in read dir", winRdData, 0);

    // R10: flush empties a filled FIFO
    regWr(0, 32'h100); regWr(1, 32'd8); byteCtr = 8'd1; regWr(0, 32'h0C0);
    mode = 4; repeat (12) @(negedge clk); goIdle();
    check(overrunFlag == 1 && winRdData == 32'h04030201, "R7 drain flagged", winRdData, 32'h04030201);
    regWr(0, 32'h100);
    check(overrunFlag == 0 && winRdData == 0, "R10 flush empties", winRdData, 0);

    // R9: timeout after three ticks without data
    regWr(2, 32'd3); regWr(1, 32'd8); regWr(0, 32'h040);
    mode = 3;
    repeat (2) @(negedge clk);
    check(dataTimeout == 0, "R9 not yet timed out", dataTimeout, 0);
    repeat (5) @(negedge clk);
    check(dataTimeout == 1, "R9 timed out", dataTimeout, 1);
    check(cardRxReady == 0, "R9 transfer halted", cardRxReady, 0);
    goIdle();

    // R2/R8: zero length completes one cycle after arming; control write clears
    regWr(0, 32'h100); regWr(1, 32'd0); regWr(0, 32'h040);
    check(dataEnd == 0, "R8 zero len not yet", dataEnd, 0);
    @(negedge clk);
    check(dataEnd == 1, "R8 zero len done", dataEnd, 1);
    regWr(0, 32'h000);
    check(dataEnd == 0, "R2 control write clears done", dataEnd, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule